// File: doc/BRIEF.md
# Saturated-Series Piecewise-Linear Function Evaluator

This block computes the nonlinear term of a multi-scroll chaotic oscillator: a saturated function series f(x), scaled by a coefficient d1, for a signed fixed-point sample x. The function has one flat saturation level per scroll, and a sloped ramp joins each neighbouring pair of levels. A parameter sets the scroll count n. All break points, levels and d1 are elaboration-time constants. The per-ramp slope, centre point and mean level are derived at elaboration, so no division happens at run time and each evaluation needs a single multiply.

A request is a one-cycle `start` pulse with `x_in`. A bank of comparators classifies x into exactly one segment. One cycle later a multiply-add stage produces either the scaled plateau level or the scaled ramp value, and marks it with `out_valid`. The evaluator accepts a new request every cycle. The integrator that owns the state variables sits outside this block and feeds x to it.

Top module: `sat_pwl_eval`

## Requirements
- R1: After synchronous reset, and after a reset that lands while a request is in flight, `out_valid` is 0 and `result` is 0.
- R2: Numbers are two's complement with INT_W integer bits (sign included) and FRAC_W fractional bits. The defaults are 8 and 14, so the value v is the integer v·16384. When x lies strictly between the upper break point of one ramp and the lower break point of the next ramp, `result` equals d1·k[p] for that plateau.
- R3: An x below the first break point gives d1·k[0], the most negative level. An x above the last break point gives d1·k[n−1], the most positive level. This holds up to the extremes of the input range.
- R4: Ramp r spans break points B[2r] to B[2r+1], both ends included. On it, `result` = D·(x − M) + A. Here D = d1·(k[r+1]−k[r])/(B[2r+1]−B[2r]), M = (B[2r]+B[2r+1])/2 and A = d1·(k[r]+k[r+1])/2. Break points are given in ascending order and levels from most negative to most positive.
- R5: Every fixed-point product is formed at double width and then shifted right arithmetically by FRAC_W, so a result that falls between two steps rounds toward minus infinity.
- R6: When `start` is 1 at a rising edge, `out_valid` is 1 for exactly one cycle after the next rising edge, with `result` for that request. Without a start, `out_valid` stays 0.
- R7: Starts on consecutive cycles give results on consecutive cycles, in request order.
- R8: While no request completes, `result` keeps its last value whatever `x_in` does.
- R9: Every x that is sampled falls into exactly one segment, whether plateau or ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe; samples `x_in` |
| x_in | input | INT_W+FRAC_W | Signed fixed-point argument |
| out_valid | output | 1 | One-cycle strobe marking a new `result` |
| result | output | INT_W+FRAC_W | Signed fixed-point d1·f(x) |

## Verification
Every result is due two rising edges after the edge that samples `start`. One edge registers the segment and the centred difference, and the next edge registers the output. The bench therefore drives on a falling edge and reads `out_valid` and `result` on the second falling edge after that. It reads again one cycle later to confirm that the strobe has dropped. In the back-to-back test the expected value for each request is checked at its own two-edge offset. The hold test reads `result` at several falling edges while `x_in` moves and no start is given.

// File: rtl/pwl_eval_pkg.sv
package pwl_eval_pkg;

    // Segment class chosen by the comparator bank.
    typedef enum logic {
        SEG_FLAT = 1'b0,
        SEG_RAMP = 1'b1
    } seg_kind_e;

    // Fixed-point product with floor rounding (arithmetic shift).
    function automatic longint fx_mul(longint a, longint b, int frac);
        longint p;
        p = a * b;
        return p >>> frac;
    endfunction

    // Fixed-point quotient, used only on elaboration constants.
    function automatic longint fx_div(longint num, longint den, int frac);
        return (num <<< frac) / den;
    endfunction

    // Midpoint of two fixed-point values.
    function automatic longint half_sum(longint a, longint b);
        return (a + b) >>> 1;
    endfunction

endpackage

// File: rtl/pwl_coef_table.sv
module pwl_coef_table
    import pwl_eval_pkg::*;
#(
    parameter int NSCROLL = 3,
    parameter int W       = 22,
    parameter int FRAC_W  = 14,
    parameter int BRK_RAW [2*(NSCROLL-1)] = '{-32768, -16384, 16384, 32768},
    parameter int LVL_RAW [NSCROLL]       = '{-32768, 0, 16384},
    parameter int D1_RAW  = 12288
) (
    output logic signed [W-1:0] flat_tab  [NSCROLL],
    output logic signed [W-1:0] mid_tab   [NSCROLL-1],
    output logic signed [W-1:0] slope_tab [NSCROLL-1],
    output logic signed [W-1:0] mean_tab  [NSCROLL-1]
);
    localparam int NRAMP = NSCROLL - 1;

    // Plateaus: d1 folded into each saturation level.
    for (genvar p = 0; p < NSCROLL; p++) begin : g_flat
        localparam longint LVL = longint'(LVL_RAW[p]);
        assign flat_tab[p] = W'(fx_mul(LVL, longint'(D1_RAW), FRAC_W));
    end

    // Ramps: slope, centre and mean level precomputed, d1 folded in.
    for (genvar r = 0; r < NRAMP; r++) begin : g_ramp
        localparam longint B_LO  = longint'(BRK_RAW[2*r]);
        localparam longint B_HI  = longint'(BRK_RAW[2*r+1]);
        localparam longint K_LO  = longint'(LVL_RAW[r]);
        localparam longint K_HI  = longint'(LVL_RAW[r+1]);
        localparam longint SLOPE = fx_div(K_HI - K_LO, B_HI - B_LO, FRAC_W);
        localparam longint MEAN  = half_sum(K_LO, K_HI);

        assign mid_tab[r]   = W'(half_sum(B_LO, B_HI));
        assign slope_tab[r] = W'(fx_mul(SLOPE, longint'(D1_RAW), FRAC_W));
        assign mean_tab[r]  = W'(fx_mul(MEAN, longint'(D1_RAW), FRAC_W));
    end

endmodule

// File: rtl/pwl_seg_select.sv
module pwl_seg_select
    import pwl_eval_pkg::*;
#(
    parameter int NSCROLL = 3,
    parameter int W       = 22,
    parameter int BRK_RAW [2*(NSCROLL-1)] = '{-32768, -16384, 16384, 32768},
    localparam int NRAMP = NSCROLL - 1,
    localparam int FIW   = (NSCROLL > 2) ? $clog2(NSCROLL) : 1,
    localparam int RIW   = (NRAMP > 2) ? $clog2(NRAMP) : 1
) (
    input  logic signed [W-1:0] x,
    output logic [NSCROLL-1:0]  hit_flat,
    output logic [NRAMP-1:0]    hit_ramp,
    output seg_kind_e           kind,
    output logic [FIW-1:0]      flat_idx,
    output logic [RIW-1:0]      ramp_idx
);
    localparam int NBP = 2 * NRAMP;

    logic signed [W-1:0] bp [NBP];

    for (genvar i = 0; i < NBP; i++) begin : g_bp
        assign bp[i] = W'(BRK_RAW[i]);
    end

    // Plateaus: outer ones clamp, inner ones lie strictly between ramps.
    for (genvar p = 0; p < NSCROLL; p++) begin : g_flat_hit
        if (p == 0) begin : g_low
            assign hit_flat[p] = (x < bp[0]);
        end else if (p == NSCROLL - 1) begin : g_high
            assign hit_flat[p] = (x > bp[NBP-1]);
        end else begin : g_mid
            assign hit_flat[p] = (x > bp[2*p-1]) && (x < bp[2*p]);
        end
    end

    // Ramps: both break points inclusive.
    for (genvar r = 0; r < NRAMP; r++) begin : g_ramp_hit
        assign hit_ramp[r] = (x >= bp[2*r]) && (x <= bp[2*r+1]);
    end

    always_comb begin
        flat_idx = '0;
        for (int p = 0; p < NSCROLL; p++) begin
            if (hit_flat[p]) flat_idx = FIW'(p);
        end
    end

    always_comb begin
        ramp_idx = '0;
        for (int r = 0; r < NRAMP; r++) begin
            if (hit_ramp[r]) ramp_idx = RIW'(r);
        end
    end

    assign kind = (|hit_ramp) ? SEG_RAMP : SEG_FLAT;

endmodule

// File: rtl/pwl_mac_stage.sv
module pwl_mac_stage
    import pwl_eval_pkg::*;
#(
    parameter int W      = 22,
    parameter int FRAC_W = 14,
    parameter int NRAMP  = 2,
    localparam int RIW   = (NRAMP > 2) ? $clog2(NRAMP) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  seg_kind_e           kind,
    input  logic [RIW-1:0]      ramp_idx,
    input  logic signed [W:0]   diff,
    input  logic signed [W-1:0] flat_val,
    input  logic signed [W-1:0] slope_tab [NRAMP],
    input  logic signed [W-1:0] mean_tab  [NRAMP],
    output logic                out_valid,
    output logic signed [W-1:0] result
);
    localparam int PW = 2 * W + 1;

    logic signed [W-1:0] slope_sel;
    logic signed [W-1:0] mean_sel;
    logic signed [PW-1:0] prod;
    logic [W-1:0]         ramp_val;
    logic                 unused_prod_bits;

    assign slope_sel = slope_tab[ramp_idx];
    assign mean_sel  = mean_tab[ramp_idx];

    // Double-width product; dropping low FRAC_W bits is a floor shift.
    assign prod     = diff * slope_sel;
    assign ramp_val = prod[FRAC_W +: W] + mean_sel;
    assign unused_prod_bits = ^{prod[FRAC_W-1:0], prod[PW-1:FRAC_W+W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= (kind == SEG_RAMP) ? $signed(ramp_val) : flat_val;
            end
        end
    end

endmodule

// File: rtl/sat_pwl_eval.sv
module sat_pwl_eval
    import pwl_eval_pkg::*;
#(
    parameter int NSCROLL = 3,
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 14,
    parameter int BRK_RAW [2*(NSCROLL-1)] = '{-32768, -16384, 16384, 32768},
    parameter int LVL_RAW [NSCROLL]       = '{-32768, 0, 16384},
    parameter int D1_RAW  = 12288
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic signed [INT_W+FRAC_W-1:0]  x_in,
    output logic                            out_valid,
    output logic signed [INT_W+FRAC_W-1:0]  result
);
    localparam int W     = INT_W + FRAC_W;
    localparam int NRAMP = NSCROLL - 1;
    localparam int NBP   = 2 * NRAMP;
    localparam int FIW   = (NSCROLL > 2) ? $clog2(NSCROLL) : 1;
    localparam int RIW   = (NRAMP > 2) ? $clog2(NRAMP) : 1;
    localparam logic signed [W-1:0] BP_LO = W'(BRK_RAW[0]);
    localparam logic signed [W-1:0] BP_HI = W'(BRK_RAW[NBP-1]);

    typedef struct packed {
        seg_kind_e           kind;
        logic [RIW-1:0]      ramp_idx;
        logic signed [W:0]   diff;
        logic signed [W-1:0] flat_val;
    } stage1_t;

    logic signed [W-1:0] flat_tab  [NSCROLL];
    logic signed [W-1:0] mid_tab   [NRAMP];
    logic signed [W-1:0] slope_tab [NRAMP];
    logic signed [W-1:0] mean_tab  [NRAMP];

    logic [NSCROLL-1:0]  hit_flat;
    logic [NRAMP-1:0]    hit_ramp;
    seg_kind_e           sel_kind;
    logic [FIW-1:0]      sel_flat_idx;
    logic [RIW-1:0]      sel_ramp_idx;
    logic signed [W-1:0] mid_sel;

    stage1_t s1_d, s1_q;
    logic    s1_valid;

    pwl_coef_table #(
        .NSCROLL (NSCROLL),
        .W       (W),
        .FRAC_W  (FRAC_W),
        .BRK_RAW (BRK_RAW),
        .LVL_RAW (LVL_RAW),
        .D1_RAW  (D1_RAW)
    ) u_coef (
        .flat_tab  (flat_tab),
        .mid_tab   (mid_tab),
        .slope_tab (slope_tab),
        .mean_tab  (mean_tab)
    );

    pwl_seg_select #(
        .NSCROLL (NSCROLL),
        .W       (W),
        .BRK_RAW (BRK_RAW)
    ) u_sel (
        .x        (x_in),
        .hit_flat (hit_flat),
        .hit_ramp (hit_ramp),
        .kind     (sel_kind),
        .flat_idx (sel_flat_idx),
        .ramp_idx (sel_ramp_idx)
    );

    // Stage 1: segment decision and centred difference.
    assign mid_sel = mid_tab[sel_ramp_idx];

    always_comb begin
        s1_d.kind     = sel_kind;
        s1_d.ramp_idx = sel_ramp_idx;
        s1_d.diff     = {x_in[W-1], x_in} - {mid_sel[W-1], mid_sel};
        s1_d.flat_val = flat_tab[sel_flat_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else begin
            s1_valid <= start;
            if (start) s1_q <= s1_d;
        end
    end

    // Stage 2: single multiply-add or plateau pass-through.
    pwl_mac_stage #(
        .W      (W),
        .FRAC_W (FRAC_W),
        .NRAMP  (NRAMP)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_valid),
        .kind      (s1_q.kind),
        .ramp_idx  (s1_q.ramp_idx),
        .diff      (s1_q.diff),
        .flat_val  (s1_q.flat_val),
        .slope_tab (slope_tab),
        .mean_tab  (mean_tab),
        .out_valid (out_valid),
        .result    (result)
    );

    // R9: the comparator bank names exactly one segment.
    a_r9_one_segment: assert property (@(posedge clk) disable iff (rst)
        start |-> ($countones({hit_flat, hit_ramp}) == 1));

    // R3: low-side clamp registers the most negative scaled level.
    a_r3_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (start && (x_in < BP_LO)) |=>
            (s1_q.kind == SEG_FLAT && s1_q.flat_val == flat_tab[0]));

    // R3: high-side clamp registers the most positive scaled level.
    a_r3_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (start && (x_in > BP_HI)) |=>
            (s1_q.kind == SEG_FLAT && s1_q.flat_val == flat_tab[NSCROLL-1]));

    // R6: a request yields a strobe two edges later.
    a_r6_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start |-> ##2 out_valid);

    // R6: no request, no strobe.
    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !start |-> ##2 !out_valid);

    // R8: the output holds when no request completes.
    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        !start |=> ##1 $stable(result));

endmodule

// File: tb/sat_pwl_eval_bench.sv
module sat_pwl_eval_bench;

    localparam int W = 22;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic signed [W-1:0] x_in = '0;
    logic                out_valid;
    logic signed [W-1:0] result;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    sat_pwl_eval u_sat_pwl_eval (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .x_in      (x_in),
        .out_valid (out_valid),
        .result    (result)
    );

    // Defaults: B = -2,-1,1,2 ; k = -2,0,1 ; d1 = 0.75 ; 1.0 == 16384.
    typedef struct packed {
        int x;
        int y;
        int req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{-81920,   -24576, 3},   // R3 x=-5, clamp low
        '{-2097152, -24576, 3},   // R3 most negative input
        '{-32769,   -24576, 3},   // R3 one step below first break point
        '{-32768,   -24576, 4},   // R4 ramp 0 lower end included
        '{-28672,   -18432, 4},   // R4 ramp 0 interior
        '{-24576,   -12288, 4},   // R4 ramp 0 centre -> mean level
        '{-16384,   0,      4},   // R4 ramp 0 upper end included
        '{-16383,   0,      2},   // R2 just inside middle plateau
        '{0,        0,      2},   // R2 middle plateau
        '{16384,    0,      4},   // R4 ramp 1 lower end
        '{20480,    3072,   4},   // R4 ramp 1 interior
        '{20481,    3072,   5},   // R5 floor of -3071.25
        '{20482,    3073,   5},   // R5 floor of -3070.5
        '{32768,    12288,  4},   // R4 ramp 1 upper end
        '{49152,    12288,  3},   // R3 clamp high
        '{2097151,  12288,  3}    // R3 most positive input
    };

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(int x, int y, int req);
        @(negedge clk);
        x_in  = W'(x);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check($sformatf("R6 valid for R%0d x=%0d", req, x), int'(out_valid), 1);
        check($sformatf("R%0d x=%0d", req, x), int'(result), y);
        @(negedge clk);
        check("R6 strobe one cycle", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 result after reset", int'(result), 0);

        for (int i = 0; i < NV; i++) begin
            run_one(VEC[i].x, VEC[i].y, VEC[i].req);
        end

        // R8: x moves without start, result keeps 12288.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            x_in = W'(-81920 + i * 1000);
            check("R8 result held", int'(result), 12288);
            check("R8 no valid", int'(out_valid), 0);
        end

        // R7: three back-to-back requests.
        @(negedge clk);
        x_in = W'(-28672); start = 1'b1;
        @(negedge clk);
        x_in = W'(20480);
        @(negedge clk);
        check("R7 first valid", int'(out_valid), 1);
        check("R7 first result", int'(result), -18432);
        x_in = W'(0);
        @(negedge clk);
        check("R7 second result", int'(result), 3072);
        check("R7 second valid", int'(out_valid), 1);
        start = 1'b0;
        @(negedge clk);
        check("R7 third result", int'(result), 0);
        check("R7 third valid", int'(out_valid), 1);
        @(negedge clk);
        check("R7 stream ends", int'(out_valid), 0);

        // R1: reset while a request is in flight.
        run_one(49152, 12288, 3);
        @(negedge clk);
        x_in = W'(-81920); start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R1 valid cleared in flight", int'(out_valid), 0);
        check("R1 result cleared in flight", int'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 no late strobe", int'(out_valid), 0);
        check("R1 result stays zero", int'(result), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule